// File: doc/BRIEF.md
# Floppy Bit-Cell Write Serializer

This block turns a stream of parallel bytes into the serial write signal for a floppy drive. Timing is synchronous to one 2 MHz reference. The reference arrives as a one-cycle enable strobe in the system clock domain. A bit cell lasts a fixed number of these strobes, and a select input sets that number: eight strobes give the slow 4 µs cell and four strobes give the fast cell at twice the bit rate. Each byte leaves most significant bit first. A one bit flips the write line at the start of its cell, and a zero bit leaves the line alone. The read side of a drive counts falling edges, so it sees one edge for every second one bit.

Bytes enter through a valid/ready handshake into a one-entry holding slot. When the last cell of a byte ends, the next byte moves from the slot into the shift register, so there is no gap between bytes. If the slot is empty at that moment, the block sends a zero byte and raises a sticky underrun flag. Dropping the write enable lets the current cell finish, then the block idles with the line level frozen.

Top module: `flop_write_serializer`

## Requirements
- R1: After reset, wr_data is 0, underrun is 0 and din_ready is 1.
- R2: When the block is idle and wr_en is 1 at a clock edge, the block starts in that edge. It loads the holding slot and begins the cell of the new byte's bit 7.
- R3: A cell ends on the edge that captures its Nth ref_tick strobe after the cell began. N is 8 when the latched mode is slow (fast_sel=0) and 4 when it is fast (fast_sel=1).
- R4: At the start of each cell, wr_data inverts if that cell's bit is 1 and holds its level if the bit is 0. It changes at no other time.
- R5: Bits leave in the order 7 down to 0. The edge that ends a byte's bit-0 cell also starts bit 7 of the next byte.
- R6: The holding slot takes din on an edge where din_valid and din_ready are both 1. din_ready is 1 exactly while the slot is empty, and a load empties the slot.
- R7: If the slot is empty when a byte must be loaded, eight zero bits are sent and underrun becomes 1. Underrun stays 1 until the next start from idle, which clears it, or sets it again if the slot is still empty.
- R8: If wr_en is 0 when a cell ends, the block goes idle at that edge and does not start the next bit. The rest of the byte is dropped, and wr_data holds its level until the next start. The holding slot keeps its byte for that next start.
- R9: The cell length follows fast_sel as sampled on the edge that loads a byte. Changes to fast_sel during a byte do not affect that byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle strobe at the 2 MHz reference rate |
| wr_en | input | 1 | Write enable; starts sending when idle, stops at the next cell end when dropped |
| fast_sel | input | 1 | 1 selects the 4-strobe cell, 0 the 8-strobe cell |
| din | input | DATA_W (8) | Byte to be written |
| din_valid | input | 1 | din holds a byte to accept |
| din_ready | output | 1 | Holding slot is empty |
| underrun | output | 1 | Sticky flag: a byte was needed and none was waiting |
| wr_data | output | 1 | Serial write line, toggling once per one bit |

## Verification
The assertions rely on ref_tick being a single-cycle pulse with idle cycles between pulses. They also rely on din and din_valid staying steady from one clock edge to the next. The bench drives every input on the falling clock edge and leaves three idle cycles after each strobe. It keeps the holding slot filled well before each byte boundary, except where underrun is being tested on purpose. It changes fast_sel and wr_en only between strobes, so each cell end can be predicted exactly by counting strobes.

// File: rtl/fws_pkg.sv
package fws_pkg;

  typedef enum logic {
    WS_IDLE = 1'b0,
    WS_SEND = 1'b1
  } wr_state_e;

  // number of reference strobes in one bit cell for a given mode
  function automatic int unsigned cell_ticks(input logic fast,
                                             input int unsigned slow_n,
                                             input int unsigned fast_n);
    return fast ? fast_n : slow_n;
  endfunction

  // line level after a cell starts carrying bit_v
  function automatic logic cell_level(input logic prev, input logic bit_v);
    return prev ^ bit_v;
  endfunction

endpackage

// File: rtl/fws_cell_timer.sv
module fws_cell_timer
  import fws_pkg::*;
#(
  parameter int unsigned SLOW_TICKS = 8,
  parameter int unsigned FAST_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic running,
  input  logic restart,
  input  logic fast_cur,
  input  logic ref_tick,
  output logic cell_end
);

  localparam int unsigned MAX_TICKS = (SLOW_TICKS > FAST_TICKS) ? SLOW_TICKS : FAST_TICKS;
  localparam int unsigned CW        = $clog2(MAX_TICKS + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] len_m1;

  assign len_m1   = CW'(cell_ticks(fast_cur, SLOW_TICKS, FAST_TICKS) - 1);
  assign cell_end = running && ref_tick && (cnt == len_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!running || restart) begin
      cnt <= '0;
    end else if (ref_tick) begin
      cnt <= cell_end ? '0 : cnt + 1'b1;
    end
  end

  // R3: the strobe count never passes the current cell length
  assert_cnt_below_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt <= len_m1));

  // R3: a cell end always restarts the count
  assert_end_clears_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cell_end |=> (cnt == '0));

endmodule

// File: rtl/fws_hold_slot.sv
module fws_hold_slot #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic              din_valid,
  output logic              din_ready,
  input  logic              pull,
  output logic              full,
  output logic [DATA_W-1:0] dout
);

  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;

  assign din_ready = !full_q;
  assign accept    = din_valid && !full_q;
  assign full      = full_q;
  assign dout      = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (accept) begin
        full_q <= 1'b1;
        data_q <= din;
      end else if (pull) begin
        full_q <= 1'b0;
      end
    end
  end

  // R6: a load only takes a byte that is present
  assert_pull_needs_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pull |-> full_q);

  // R6: an accepted byte is held for the next load
  assert_accept_fills_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (din_valid && din_ready) |=> (full_q && (data_q == $past(din))));

endmodule

// File: rtl/fws_toggle_out.sv
module fws_toggle_out
  import fws_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cell_start,
  input  logic cell_bit,
  output logic wr_data
);

  logic lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
    end else if (cell_start) begin
      lvl_q <= cell_level(lvl_q, cell_bit);
    end
  end

  assign wr_data = lvl_q;

  // R4: the line moves only for a one bit at a cell start
  assert_flip_only_for_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cell_start && cell_bit) |=> $stable(wr_data));

  // R4: every one bit moves the line
  assert_one_flips_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_start && cell_bit) |=> (wr_data != $past(wr_data)));

endmodule

// File: rtl/flop_write_serializer.sv
module flop_write_serializer
  import fws_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned SLOW_TICKS = 8,
  parameter int unsigned FAST_TICKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              wr_en,
  input  logic              fast_sel,
  input  logic [DATA_W-1:0] din,
  input  logic              din_valid,
  output logic              din_ready,
  output logic              underrun,
  output logic              wr_data
);

  localparam int unsigned        BW       = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BW-1:0]      LAST_POS = BW'(DATA_W - 1);

  wr_state_e         state;
  logic [DATA_W-1:0] shreg;
  logic [BW-1:0]     bit_pos;
  logic              mode_fast;
  logic              underrun_q;

  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic [DATA_W-1:0] next_byte;

  // named events for control and assertions
  logic start_ev;
  logic cell_end;
  logic adv_ev;
  logic stop_ev;
  logic last_cell;
  logic load_ev;
  logic pull;
  logic starve_ev;
  logic cell_start;
  logic cell_bit;

  assign start_ev   = (state == WS_IDLE) && wr_en;
  assign last_cell  = (bit_pos == LAST_POS);
  assign adv_ev     = (state == WS_SEND) && cell_end && wr_en;
  assign stop_ev    = (state == WS_SEND) && cell_end && !wr_en;
  assign load_ev    = start_ev || (adv_ev && last_cell);
  assign pull       = load_ev && hold_full;
  assign starve_ev  = load_ev && !hold_full;
  assign next_byte  = hold_full ? hold_data : '0;
  assign cell_start = load_ev || (adv_ev && !last_cell);
  assign cell_bit   = load_ev ? next_byte[DATA_W-1] : shreg[DATA_W-2];

  fws_hold_slot #(.DATA_W(DATA_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (din),
    .din_valid (din_valid),
    .din_ready (din_ready),
    .pull      (pull),
    .full      (hold_full),
    .dout      (hold_data)
  );

  fws_cell_timer #(.SLOW_TICKS(SLOW_TICKS), .FAST_TICKS(FAST_TICKS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .running  (state == WS_SEND),
    .restart  (start_ev),
    .fast_cur (mode_fast),
    .ref_tick (ref_tick),
    .cell_end (cell_end)
  );

  fws_toggle_out u_line (
    .clk        (clk),
    .rst_n      (rst_n),
    .cell_start (cell_start),
    .cell_bit   (cell_bit),
    .wr_data    (wr_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= WS_IDLE;
      shreg     <= '0;
      bit_pos   <= '0;
      mode_fast <= 1'b0;
    end else begin
      if (load_ev) begin
        state     <= WS_SEND;
        shreg     <= next_byte;
        bit_pos   <= '0;
        mode_fast <= fast_sel;
      end else if (adv_ev) begin
        shreg   <= shreg << 1;
        bit_pos <= bit_pos + 1'b1;
      end else if (stop_ev) begin
        state   <= WS_IDLE;
        shreg   <= '0;
        bit_pos <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      underrun_q <= 1'b0;
    end else if (starve_ev) begin
      underrun_q <= 1'b1;
    end else if (start_ev) begin
      underrun_q <= 1'b0;
    end
  end

  assign underrun = underrun_q;

  // R7: the flag stays up until a new start from idle
  assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_q && !start_ev) |=> underrun_q);

  // R7: a load with nothing waiting raises the flag
  assert_starve_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    starve_ev |=> underrun);

  // R8: a cell end with wr_en low leaves the block idle
  assert_stop_goes_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (state == WS_IDLE));

  // R8: the line level is frozen while idle
  assert_idle_level_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == WS_IDLE) && !start_ev) |=> $stable(wr_data));

  // R9: the cell mode only moves when a byte is loaded
  assert_mode_fixed_in_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ev |=> $stable(mode_fast));

endmodule

// File: tb/flop_write_serializer_test.sv
module flop_write_serializer_test;

  localparam int GAP   = 3;
  localparam int NARR  = 264;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_tick;
  logic       wr_en;
  logic       fast_sel;
  logic [7:0] din;
  logic       din_valid;
  logic       din_ready;
  logic       underrun;
  logic       wr_data;

  always #5 clk = ~clk;

  flop_write_serializer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_tick  (ref_tick),
    .wr_en     (wr_en),
    .fast_sel  (fast_sel),
    .din       (din),
    .din_valid (din_valid),
    .din_ready (din_ready),
    .underrun  (underrun),
    .wr_data   (wr_data)
  );

  int         n_checks = 0;
  int         n_fails  = 0;
  logic [7:0] arr [0:NARR-1];
  int         avail = 0;
  int         fi    = 0;
  logic       take  = 1'b0;

  // expected-state of the stream
  logic       lvl = 1'b0;
  logic [7:0] cur = 8'h00;
  int         pos = 0;
  int         clen = 8;
  int         e = 0;
  logic       und_exp = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // feeder: keeps the holding slot filled while bytes are available
  initial begin
    din_valid = 1'b0;
    din       = 8'h00;
    forever begin
      @(negedge clk);
      if (take) fi++;
      din_valid = (fi < avail);
      din       = (fi < avail) ? arr[fi] : 8'h00;
      take      = din_valid && din_ready;
    end
  end

  task automatic do_tick();
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic load_expect(input string req);
    if (e < avail) begin
      cur = arr[e];
      e++;
    end else begin
      cur     = 8'h00;
      und_exp = 1'b1;
    end
    clen = fast_sel ? 4 : 8;
    pos  = 0;
    lvl  = lvl ^ cur[7];
    chk(req, wr_data, lvl);
    chk("R7 underrun at load", underrun, und_exp);
  endtask

  task automatic run_cells(input int n);
    for (int c = 0; c < n; c++) begin
      for (int t = 0; t < clen - 1; t++) do_tick();
      chk("R3 no change before last strobe", wr_data, lvl);
      do_tick();
      pos++;
      if (pos == 8) begin
        load_expect("R5 next byte starts gapless");
      end else begin
        lvl = lvl ^ cur[7 - pos];
        chk("R4 cell start level", wr_data, lvl);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    arr[0] = 8'hA5; arr[1] = 8'hFF; arr[2] = 8'h00; arr[3] = 8'h3C; arr[4] = 8'h81;
    for (int k = 0; k < 256; k++) arr[5 + k] = 8'(k);
    arr[261] = 8'hF0; arr[262] = 8'h5A; arr[263] = 8'hC3;

    rst_n    = 1'b0;
    ref_tick = 1'b0;
    wr_en    = 1'b0;
    fast_sel = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 wr_data", wr_data, 1'b0);
    chk("R1 underrun", underrun, 1'b0);
    chk("R1 din_ready", din_ready, 1'b1);

    // R6 slot fills and ready drops
    avail = 5;
    repeat (4) @(negedge clk);
    chk("R6 ready low when full", din_ready, 1'b0);

    // R2 start in slow mode
    wr_en = 1'b1;
    @(negedge clk);
    load_expect("R2 start loads bit 7");

    // three slow bytes, into byte 3
    run_cells(24);
    run_cells(1);
    // R9: mid-byte switch must not shorten the rest of byte 3
    fast_sel = 1'b1;
    run_cells(7);
    // byte 4 in fast mode, then byte 5 starved
    run_cells(8);
    chk("R7 underrun raised", underrun, 1'b1);

    // refill; R6 slot takes next byte during the zero byte
    avail = NARR;
    repeat (4) @(negedge clk);
    chk("R6 ready low when refilled", din_ready, 1'b0);
    run_cells(8);

    // sweep every byte value in fast mode, flag remains sticky (R7)
    run_cells(256 * 8);
    chk("R7 flag still sticky", underrun, 1'b1);

    // now in F0 byte; move to bit 5, then stop
    run_cells(2);
    do_tick();
    wr_en = 1'b0;
    repeat (clen - 2) do_tick();
    chk("R8 cell still running", wr_data, lvl);
    do_tick();
    chk("R8 no toggle after stop", wr_data, lvl);
    for (int k = 0; k < 8; k++) begin
      do_tick();
      chk("R8 level held idle", wr_data, lvl);
    end
    chk("R8 slot kept byte", din_ready, 1'b0);

    // restart: clears the flag and loads the waiting byte
    wr_en = 1'b1;
    @(negedge clk);
    und_exp = 1'b0;
    load_expect("R2 restart loads bit 7");
    chk("R7 cleared on restart", underrun, 1'b0);
    run_cells(15);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule